// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregation Controller

This block gathers interrupt events from two PHY ports, six general-purpose input pins, a 16-bit down-counting timer, a software request and a post-reset ready indication, and folds them into one active-high interrupt line. The events are held in two levels of registers. The lower level keeps a latched status bit and an enable (mask) bit for every PHY event and every input pin. The top level holds one read-only summary bit for each lower-level group, next to status bits that are set directly by the timer, the software request and the ready sequencer.

An event reaches the `irq` pin only if it passes three gates: its own source mask, the matching bit in the top-level enable register and the global output enable. Software reads and writes the registers through a synchronous single-cycle write strobe with combinational read data. Latched status bits are cleared by writing 1 to them.

Register map (word addresses): 0 top status, 1 top enable, 2 global control (bit 0 = output enable), 3 port A status, 4 port A mask, 5 port B status, 6 port B mask, 7 pin register (status bits [5:0], enable bits [13:8]), 8 timer control (bit 0 = run), 9 timer reload, 10 timer count (read-only). Top-level bit positions in both the status and the enable register: 0 port A, 1 port B, 2 pins, 3 timer, 4 software, 5 ready. PHY event bits: 0 link lost, 1 partner acknowledge, 2 parallel-detect fault, 3 page received.

Top module: `irq_hub`

## Requirements
- R1: After reset the top status, the top enable, all lower status and mask bits, and `irq` are 0, and the timer reload register reads FFFFh.
- R2: A pulse on bit k of a PHY event input sets bit k of that port's status register. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R3: `irq` goes high one clock after a masked-in source, its top enable bit and the global enable bit (address 2, bit 0) all hold. It stays low while any of the three is missing.
- R4: When a lower-level event and a write-1 clear of the same bit occur in the same cycle, the bit ends up set.
- R5: A top summary bit (0, 1 or 2) reads 1 exactly when some status bit of its group has its mask bit set. Writes to the top status register do not change it.
- R6: A rising edge on input pin k sets status bit k of the pin register (address 7). A pin that stays high does not set the bit again. The enable bits [13:8] feed the pin summary bit 2.
- R7: Writing run=1 loads the counter from the reload register. The counter then decrements once every PRESC cycles (default 4). Counting past zero wraps it to FFFFh and sets top status bit 3. With run=0 the counter does not move and bit 3 is not set.
- R8: Top status bit 3 is cleared by writing 1 to it, and writing 0 to it has no effect.
- R9: Top status bit 4 becomes 1 one cycle after top enable bit 4 is set, and becomes 0 one cycle after that enable bit is cleared.
- R10: Top status bit 5 becomes 1 on the RDY_DLY-th clock after reset release (default 16). It clears on a write of 1 and is not set again until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| phy_a_evt | input | 4 | Port A single-cycle event pulses |
| phy_b_evt | input | 4 | Port B single-cycle event pulses |
| gpio_in | input | 6 | Input pins, edge-detected |
| irq | output | 1 | Registered active-high interrupt line |

## Verification
The assertions assume that PHY event inputs are single-cycle pulses that are synchronous to `clk`. They assume that the pin inputs change only between clock edges, and that a write lasts exactly one cycle with a stable address and data. The stimulus drives every input on the falling edge, keeps each PHY pulse to one cycle and never issues back-to-back writes without a gap. The same-cycle event-and-clear case of R4 is produced on purpose, because the latching assertions must hold through it.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int DW = 16;
    localparam int AW = 4;

    typedef enum logic [AW-1:0] {
        A_TOP_STAT   = 4'd0,
        A_TOP_EN     = 4'd1,
        A_GLB_CTL    = 4'd2,
        A_PHYA_STAT  = 4'd3,
        A_PHYA_MASK  = 4'd4,
        A_PHYB_STAT  = 4'd5,
        A_PHYB_MASK  = 4'd6,
        A_PIN_REG    = 4'd7,
        A_TMR_CTL    = 4'd8,
        A_TMR_RELOAD = 4'd9,
        A_TMR_COUNT  = 4'd10
    } reg_addr_e;

    // top-level bit positions, shared by status and enable
    localparam int B_PHYA = 0;
    localparam int B_PHYB = 1;
    localparam int B_PIN  = 2;
    localparam int B_TMR  = 3;
    localparam int B_SOFT = 4;
    localparam int B_RDY  = 5;
    localparam int NTOP   = 6;
    localparam int PIN_EN_LSB = 8;
endpackage

// File: rtl/evt_bank.sv
module evt_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wd,
    output logic [N-1:0] stat,
    output logic [N-1:0] mask,
    output logic         summary
);
    typedef struct packed {
        logic [N-1:0] stat;
        logic [N-1:0] mask;
    } bank_t;

    bank_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.stat = (cur_q.stat & ~clr) | evt;
        if (mask_we) nxt_d.mask = mask_wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign stat    = cur_q.stat;
    assign mask    = cur_q.mask;
    assign summary = |(cur_q.stat & cur_q.mask);

    // R4: an event is never lost, even against a same-cycle clear
    assert_evt_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((stat & $past(evt)) == $past(evt)));

    for (genvar i = 0; i < N; i++) begin : g_hold
        // R2: a set bit without a clear stays set
        assert_w1c_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[i] && !clr[i]) |=> stat[i]);
    end
endmodule

// File: rtl/wrap_timer.sv
module wrap_timer #(
    parameter int W     = 16,
    parameter int PRESC = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         reload_we,
    input  logic [W-1:0] reload_wd,
    output logic [W-1:0] count,
    output logic [W-1:0] reload,
    output logic         wrap
);
    localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam logic [PW-1:0] PLAST = PW'(PRESC - 1);

    typedef struct packed {
        logic [W-1:0]  reload;
        logic [W-1:0]  count;
        logic [PW-1:0] pre;
        logic          run_prev;
    } tmr_t;

    tmr_t cur_q, nxt_d;
    logic tick;

    assign tick = run && cur_q.run_prev && (cur_q.pre == PLAST);
    assign wrap = tick && (cur_q.count == '0);

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.run_prev = run;
        if (reload_we) nxt_d.reload = reload_wd;
        if (run && !cur_q.run_prev) begin
            nxt_d.count = cur_q.reload;
            nxt_d.pre   = '0;
        end else if (run) begin
            if (tick) begin
                nxt_d.pre   = '0;
                nxt_d.count = cur_q.count - 1'b1;
            end else begin
                nxt_d.pre = cur_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q        <= '0;
            cur_q.reload <= '1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign count  = cur_q.count;
    assign reload = cur_q.reload;

    assert_wrap_ffff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '1));
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(count));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int PHY_N   = 4,
    parameter int PIN_N   = 6,
    parameter int TMR_W   = 16,
    parameter int PRESC   = 4,
    parameter int RDY_DLY = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [PHY_N-1:0] phy_a_evt,
    input  logic [PHY_N-1:0] phy_b_evt,
    input  logic [PIN_N-1:0] gpio_in,
    output logic             irq
);
    localparam int RCW = $clog2(RDY_DLY + 1);

    typedef struct packed {
        logic [NTOP-1:0]  top_en;
        logic             glb;
        logic             tmr_run;
        logic             tmr_st;
        logic             soft_st;
        logic             rdy_st;
        logic             rdy_done;
        logic [RCW-1:0]   rdy_cnt;
        logic [PIN_N-1:0] pin_prev;
        logic             irq;
    } hub_t;

    hub_t cur_q, nxt_d;
    reg_addr_e addr;
    logic [PHY_N-1:0] a_stat, a_mask, b_stat, b_mask;
    logic [PIN_N-1:0] p_stat, p_mask;
    logic a_sum, b_sum, p_sum, tmr_wrap;
    logic [TMR_W-1:0] tmr_cnt, tmr_rld;
    logic [NTOP-1:0] top_stat;
    logic top_clr_hit;

    assign addr        = reg_addr_e'(bus_addr);
    assign top_clr_hit = bus_we && (addr == A_TOP_STAT);

    evt_bank #(.N(PHY_N)) u_phya (
        .clk(clk), .rst_n(rst_n), .evt(phy_a_evt),
        .clr((bus_we && addr == A_PHYA_STAT) ? bus_wdata[PHY_N-1:0] : '0),
        .mask_we(bus_we && addr == A_PHYA_MASK), .mask_wd(bus_wdata[PHY_N-1:0]),
        .stat(a_stat), .mask(a_mask), .summary(a_sum));

    evt_bank #(.N(PHY_N)) u_phyb (
        .clk(clk), .rst_n(rst_n), .evt(phy_b_evt),
        .clr((bus_we && addr == A_PHYB_STAT) ? bus_wdata[PHY_N-1:0] : '0),
        .mask_we(bus_we && addr == A_PHYB_MASK), .mask_wd(bus_wdata[PHY_N-1:0]),
        .stat(b_stat), .mask(b_mask), .summary(b_sum));

    evt_bank #(.N(PIN_N)) u_pins (
        .clk(clk), .rst_n(rst_n), .evt(gpio_in & ~cur_q.pin_prev),
        .clr((bus_we && addr == A_PIN_REG) ? bus_wdata[PIN_N-1:0] : '0),
        .mask_we(bus_we && addr == A_PIN_REG),
        .mask_wd(bus_wdata[PIN_EN_LSB +: PIN_N]),
        .stat(p_stat), .mask(p_mask), .summary(p_sum));

    wrap_timer #(.W(TMR_W), .PRESC(PRESC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(cur_q.tmr_run),
        .reload_we(bus_we && addr == A_TMR_RELOAD), .reload_wd(bus_wdata[TMR_W-1:0]),
        .count(tmr_cnt), .reload(tmr_rld), .wrap(tmr_wrap));

    always_comb begin
        top_stat         = '0;
        top_stat[B_PHYA] = a_sum;
        top_stat[B_PHYB] = b_sum;
        top_stat[B_PIN]  = p_sum;
        top_stat[B_TMR]  = cur_q.tmr_st;
        top_stat[B_SOFT] = cur_q.soft_st;
        top_stat[B_RDY]  = cur_q.rdy_st;
    end

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.pin_prev = gpio_in;
        if (bus_we) begin
            unique case (addr)
                A_TOP_EN:  nxt_d.top_en  = bus_wdata[NTOP-1:0];
                A_GLB_CTL: nxt_d.glb     = bus_wdata[0];
                A_TMR_CTL: nxt_d.tmr_run = bus_wdata[0];
                default: ;
            endcase
        end
        if (top_clr_hit && bus_wdata[B_RDY]) nxt_d.rdy_st = 1'b0;
        nxt_d.tmr_st  = (cur_q.tmr_st && !(top_clr_hit && bus_wdata[B_TMR])) || tmr_wrap;
        nxt_d.soft_st = cur_q.top_en[B_SOFT];
        if (!cur_q.rdy_done) begin
            nxt_d.rdy_cnt = cur_q.rdy_cnt + 1'b1;
            if (cur_q.rdy_cnt == RCW'(RDY_DLY - 1)) begin
                nxt_d.rdy_done = 1'b1;
                nxt_d.rdy_st   = 1'b1;
            end
        end
        nxt_d.irq = cur_q.glb && |(top_stat & cur_q.top_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (addr)
            A_TOP_STAT:   bus_rdata[NTOP-1:0]  = top_stat;
            A_TOP_EN:     bus_rdata[NTOP-1:0]  = cur_q.top_en;
            A_GLB_CTL:    bus_rdata[0]         = cur_q.glb;
            A_PHYA_STAT:  bus_rdata[PHY_N-1:0] = a_stat;
            A_PHYA_MASK:  bus_rdata[PHY_N-1:0] = a_mask;
            A_PHYB_STAT:  bus_rdata[PHY_N-1:0] = b_stat;
            A_PHYB_MASK:  bus_rdata[PHY_N-1:0] = b_mask;
            A_PIN_REG: begin
                bus_rdata[PIN_N-1:0]           = p_stat;
                bus_rdata[PIN_EN_LSB +: PIN_N] = p_mask;
            end
            A_TMR_CTL:    bus_rdata[0]         = cur_q.tmr_run;
            A_TMR_RELOAD: bus_rdata[TMR_W-1:0] = tmr_rld;
            A_TMR_COUNT:  bus_rdata[TMR_W-1:0] = tmr_cnt;
            default: ;
        endcase
    end

    assign irq = cur_q.irq;

    assert_gate_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_q.glb |=> !irq);
    assert_tmr_w0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.tmr_st && !(top_clr_hit && bus_wdata[B_TMR])) |=> cur_q.tmr_st);
    assert_soft_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.top_en[B_SOFT] |=> cur_q.soft_st);
    assert_rdy_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.rdy_done |=> !$rose(cur_q.rdy_st));
endmodule

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  phy_a_evt = '0, phy_b_evt = '0;
    logic [5:0]  gpio_in = '0;
    logic        irq;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_hub u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .phy_a_evt(phy_a_evt),
        .phy_b_evt(phy_b_evt), .gpio_in(gpio_in), .irq(irq));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #0.5 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(4'd0, v); chk("R1 top status", v, 16'h0);
        rd(4'd1, v); chk("R1 top enable", v, 16'h0);
        rd(4'd9, v); chk("R1 reload", v, 16'hFFFF);
        rd(4'd3, v); chk("R1 port A status", v, 16'h0);
        chk("R1 irq", {15'b0, irq}, 16'h0);
        repeat (8) @(negedge clk);
        rd(4'd0, v); chk("R10 not yet ready", v & 16'h20, 16'h0);
        repeat (10) @(negedge clk);
        rd(4'd0, v); chk("R10 ready set", v & 16'h20, 16'h20);
        wr(4'd0, 16'h0020);
        rd(4'd0, v); chk("R10 ready cleared", v & 16'h20, 16'h0);
        repeat (30) @(negedge clk);
        rd(4'd0, v); chk("R10 ready stays clear", v & 16'h20, 16'h0);
    endtask

    task automatic t_phy();
        logic [15:0] v;
        @(negedge clk); phy_a_evt = 4'b0101;
        @(negedge clk); phy_a_evt = 4'b0000;
        rd(4'd3, v); chk("R2 latch", v, 16'h0005);
        rd(4'd0, v); chk("R5 masked summary", v & 16'h1, 16'h0);
        wr(4'd4, 16'h0001);
        rd(4'd0, v); chk("R5 summary set", v & 16'h1, 16'h1);
        wr(4'd0, 16'h0001);
        rd(4'd0, v); chk("R5 summary read-only", v & 16'h1, 16'h1);
        chk("R3 no top enable", {15'b0, irq}, 16'h0);
        wr(4'd1, 16'h0001);
        @(negedge clk);
        chk("R3 no global enable", {15'b0, irq}, 16'h0);
        wr(4'd2, 16'h0001);
        @(negedge clk);
        chk("R3 all gates open", {15'b0, irq}, 16'h1);
        wr(4'd3, 16'h0004);
        rd(4'd3, v); chk("R2 w1c one bit", v, 16'h0001);
        rd(4'd0, v); chk("R5 summary kept", v & 16'h1, 16'h1);
        wr(4'd3, 16'h0000);
        rd(4'd3, v); chk("R2 write 0 no effect", v, 16'h0001);
        wr(4'd3, 16'h0001);
        rd(4'd0, v); chk("R5 summary cleared", v & 16'h1, 16'h0);
        @(negedge clk);
        chk("R3 irq drops", {15'b0, irq}, 16'h0);
        // port B: same-cycle event and clear
        @(negedge clk); phy_b_evt = 4'b0010;
        @(negedge clk); phy_b_evt = 4'b0000;
        bus_we = 1'b1; bus_addr = 4'd5; bus_wdata = 16'h0002; phy_b_evt = 4'b0010;
        @(negedge clk); bus_we = 1'b0; phy_b_evt = 4'b0000;
        rd(4'd5, v); chk("R4 event wins over clear", v, 16'h0002);
        wr(4'd6, 16'h0002);
        rd(4'd0, v); chk("R5 port B summary", v & 16'h2, 16'h2);
        @(negedge clk);
        chk("R3 port B top enable off", {15'b0, irq}, 16'h0);
        wr(4'd5, 16'h0002);
        rd(4'd5, v); chk("R2 port B cleared", v, 16'h0);
    endtask

    task automatic t_pins();
        logic [15:0] v;
        wr(4'd1, 16'h0004);
        @(negedge clk); gpio_in = 6'b001000;
        @(negedge clk);
        rd(4'd7, v); chk("R6 edge latched", v, 16'h0008);
        rd(4'd0, v); chk("R6 summary needs enable", v & 16'h4, 16'h0);
        wr(4'd7, 16'h0808);
        repeat (3) @(negedge clk);
        rd(4'd7, v); chk("R6 held level no re-set", v, 16'h0800);
        gpio_in = 6'b0;
        @(negedge clk); gpio_in = 6'b001000;
        @(negedge clk);
        rd(4'd7, v); chk("R6 new edge", v, 16'h0808);
        rd(4'd0, v); chk("R6 summary", v & 16'h4, 16'h4);
        @(negedge clk);
        chk("R3 pin irq", {15'b0, irq}, 16'h1);
        wr(4'd7, 16'h0808);
        @(negedge clk);
        chk("R3 pin irq cleared", {15'b0, irq}, 16'h0);
        gpio_in = 6'b0;
    endtask

    task automatic t_timer();
        logic [15:0] v;
        int n = 0;
        wr(4'd1, 16'h0008);
        wr(4'd9, 16'h0003);
        repeat (40) @(negedge clk);
        rd(4'd0, v);  chk("R7 idle no wrap", v & 16'h8, 16'h0);
        rd(4'd10, v); chk("R7 idle count", v, 16'h0);
        wr(4'd8, 16'h0001);
        rd(4'd0, v);
        while (v[3] == 1'b0 && n < 100) begin
            @(negedge clk); n++;
            rd(4'd0, v);
        end
        chk("R7 wrap cycle", 16'(n), 16'd17);
        rd(4'd10, v); chk("R7 wrapped to FFFF", v, 16'hFFFF);
        @(negedge clk);
        chk("R3 timer irq", {15'b0, irq}, 16'h1);
        wr(4'd8, 16'h0000);
        wr(4'd0, 16'h0000);
        rd(4'd0, v); chk("R8 write 0 keeps", v & 16'h8, 16'h8);
        wr(4'd0, 16'h0008);
        rd(4'd0, v); chk("R8 write 1 clears", v & 16'h8, 16'h0);
    endtask

    task automatic t_soft();
        logic [15:0] v;
        wr(4'd1, 16'h0010);
        rd(4'd0, v); chk("R9 one-cycle lag", v & 16'h10, 16'h0);
        @(negedge clk);
        rd(4'd0, v); chk("R9 soft set", v & 16'h10, 16'h10);
        @(negedge clk);
        chk("R3 soft irq", {15'b0, irq}, 16'h1);
        wr(4'd1, 16'h0000);
        @(negedge clk);
        rd(4'd0, v); chk("R9 soft cleared", v & 16'h10, 16'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_phy();
        t_pins();
        t_timer();
        t_soft();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule